// File: doc/BRIEF.md
# Per-Bank Open-Row Timing Tracker

This block keeps the bank state of a four-bank SDRAM and decides whether each kind of command may legally issue in the current cycle. A controller front end presents one intended command: an operation code, a bank and a row. In the same cycle the block answers with three things. It gives the row status of that bank: idle, row hit or row miss. It gives an "allowed now" bit for every operation code, evaluated against the presented bank and row. It also says whether a command marked valid is accepted. Only accepted commands change the tracked state.

Banks follow an open-bank policy. An activation leaves the bank open on its row until a precharge on that bank or a precharge-all closes it. Every minimum spacing is held in a saturating down counter. The spacings cover activate to column access, activate to precharge, activate to activate on the same bank and on different banks, precharge to activate, read and write to precharge, write to read, refresh to activate, mode load to activate or refresh, and the exits from self-refresh and power-down. A counter at zero means that its constraint is met. When one command places several constraints on the same counter, the longest one holds. All spacings are sampled from configuration inputs while reset is high.

Top module: `bank_timing_tracker`

## Requirements
- R1: While `rst` is high the thirteen spacing inputs are captured. After reset every bank is idle (`open_mask` = 0), and no spacing is pending, so an activate to any bank is allowed in the first cycle.
- R2: Operation codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, REF=6, MRS=7, SRX=8, PDX=9, and `allow` bit i belongs to code i. `q_status` reports 0 for an idle bank, 1 when the bank is open on `cmd_row` and 2 when it is open on another row. ACT is allowed only on an idle bank and opens it on the given row.
- R3: RD and WR are allowed only on a row hit, and only once the activate-to-access spacing has passed since that bank's activation.
- R4: PRE is allowed only on an open bank. It waits for the activate-to-precharge, read-to-precharge and write-to-precharge spacings of that bank. It closes the bank, and a new ACT to that bank then waits the precharge-to-activate spacing.
- R5: A new ACT waits the row-cycle spacing after an ACT to the same bank and the bank-to-bank spacing after an ACT to any other bank.
- R6: After a WR to any bank, RD to every bank waits the write-to-read spacing.
- R7: PREA is allowed once every open bank meets its precharge spacings. It closes all banks and applies the precharge-to-activate spacing to every bank.
- R8: REF is allowed only when all banks are idle and every bank's activate spacing has elapsed. A following ACT waits the refresh-to-activate spacing.
- R9: MRS obeys the same condition as REF. ACT and REF after it wait the mode-load spacing.
- R10: After SRX, every command other than NOP, SRX and PDX waits the self-refresh non-read spacing, and RD also waits the longer self-refresh read spacing. After PDX, every such command waits the power-down exit spacing. NOP, SRX and PDX are always allowed.
- R11: A valid command that is not allowed, or that carries a code above 9, is not accepted and changes no bank state or counter.
- R12: A spacing value N loaded by a command issued in cycle t allows the constrained command from cycle t+max(N,1). Overlapping constraints on the same counter keep the longest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; spacing inputs are captured while high |
| cfg_act_pre | input | 8 | Activate to precharge, same bank |
| cfg_act_rw | input | 8 | Activate to read or write, same bank |
| cfg_pre_act | input | 8 | Precharge to activate |
| cfg_wr_pre | input | 8 | Write to precharge, same bank |
| cfg_rd_pre | input | 8 | Read to precharge, same bank |
| cfg_wr_rd | input | 8 | Write to read, any bank |
| cfg_act_xb | input | 8 | Activate to activate, different banks |
| cfg_act_sb | input | 8 | Activate to activate, same bank |
| cfg_ref_act | input | 8 | Refresh to activate |
| cfg_mrs_cmd | input | 8 | Mode load to activate or refresh |
| cfg_srx_cmd | input | 8 | Self-refresh exit to non-read command |
| cfg_srx_rd | input | 8 | Self-refresh exit to read |
| cfg_pdx_cmd | input | 8 | Power-down exit to any command |
| cmd_valid | input | 1 | Presented command is to be issued this cycle |
| cmd_op | input | 4 | Operation code (R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 14 | Target row |
| q_status | output | 2 | Row status of `cmd_bank` against `cmd_row` |
| allow | output | 10 | Per-code allowed-now bits for the presented bank and row |
| cmd_accept | output | 1 | Valid command accepted and applied at this edge |
| open_mask | output | 4 | One bit per bank, set while that bank is open |

## Verification
A wrong open flag or stored row shows at once as a wrong `q_status` and as wrong ACT, RD or WR allow bits for the bank being queried. A miscounted spacing moves the first cycle in which an allow bit rises. The bench therefore measures, for every pairing of commands, the exact cycle offset at which the bit rises, and compares it with the value that follows from the captured spacings. A state change made by a rejected command shows up in the next query of the same bank, through the stored row or the remaining allow bits.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
  parameter int unsigned CNT_W   = 8;
  parameter int unsigned OP_W    = 4;
  parameter int unsigned NUM_OPS = 10;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ACT  = 4'd1,
    OP_RD   = 4'd2,
    OP_WR   = 4'd3,
    OP_PRE  = 4'd4,
    OP_PREA = 4'd5,
    OP_REF  = 4'd6,
    OP_MRS  = 4'd7,
    OP_SRX  = 4'd8,
    OP_PDX  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_MISS = 2'd2
  } status_e;

  // Captured spacing set, one field per constraint.
  typedef struct packed {
    logic [CNT_W-1:0] act_pre;
    logic [CNT_W-1:0] act_rw;
    logic [CNT_W-1:0] pre_act;
    logic [CNT_W-1:0] wr_pre;
    logic [CNT_W-1:0] rd_pre;
    logic [CNT_W-1:0] wr_rd;
    logic [CNT_W-1:0] act_xb;
    logic [CNT_W-1:0] act_sb;
    logic [CNT_W-1:0] ref_act;
    logic [CNT_W-1:0] mrs_cmd;
    logic [CNT_W-1:0] srx_cmd;
    logic [CNT_W-1:0] srx_rd;
    logic [CNT_W-1:0] pdx_cmd;
  } timing_t;
endpackage

// File: rtl/gap_timer.sv
// Saturating down counter fed by several spacing sources; the longest load wins.
module gap_timer #(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSRC-1:0]           load,
  input  logic [NSRC-1:0][W-1:0]    span,
  output logic                      idle
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    for (int i = 0; i < NSRC; i++) begin
      if (load[i] && (span[i] != '0) && ((span[i] - 1'b1) > cnt_d)) begin
        cnt_d = span[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);

  // R12: without a load the counter only walks down by one.
  assert_count_down_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && load == '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R12: a pending count never vanishes on a load.
  assert_keep_longest_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > 8'd1) |=> !idle);
endmodule

// File: rtl/bank_slot.sv
// State of one bank: open flag, stored row and its three spacing timers.
module bank_slot
  import bank_trk_pkg::*;
#(
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [OP_W-1:0]  fire_op,
  input  logic             fire_here,
  input  logic [ROW_W-1:0] fire_row,
  input  logic [CNT_W-1:0] t_act_sb,
  input  logic [CNT_W-1:0] t_act_xb,
  input  logic [CNT_W-1:0] t_pre_act,
  input  logic [CNT_W-1:0] t_ref_act,
  input  logic [CNT_W-1:0] t_mrs_cmd,
  input  logic [CNT_W-1:0] t_act_rw,
  input  logic [CNT_W-1:0] t_act_pre,
  input  logic [CNT_W-1:0] t_rd_pre,
  input  logic [CNT_W-1:0] t_wr_pre,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok,
  output logic             rw_ok,
  output logic             pre_ok
);
  logic act_me, act_other, rd_me, wr_me, pre_me, prea_all, ref_all, mrs_all;

  assign act_me    = fire &&  fire_here && (fire_op == OP_ACT);
  assign act_other = fire && !fire_here && (fire_op == OP_ACT);
  assign rd_me     = fire &&  fire_here && (fire_op == OP_RD);
  assign wr_me     = fire &&  fire_here && (fire_op == OP_WR);
  assign pre_me    = fire &&  fire_here && (fire_op == OP_PRE);
  assign prea_all  = fire && (fire_op == OP_PREA);
  assign ref_all   = fire && (fire_op == OP_REF);
  assign mrs_all   = fire && (fire_op == OP_MRS);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (act_me) begin
      open_o <= 1'b1;
      row_o  <= fire_row;
    end else if (pre_me || prea_all) begin
      open_o <= 1'b0;
    end
  end

  gap_timer #(.W(CNT_W), .NSRC(6)) u_act_gap (
    .clk  (clk),
    .rst  (rst),
    .load ({act_me, act_other, pre_me, prea_all, ref_all, mrs_all}),
    .span ({t_act_sb, t_act_xb, t_pre_act, t_pre_act, t_ref_act, t_mrs_cmd}),
    .idle (act_ok)
  );

  gap_timer #(.W(CNT_W), .NSRC(1)) u_rw_gap (
    .clk  (clk),
    .rst  (rst),
    .load (act_me),
    .span (t_act_rw),
    .idle (rw_ok)
  );

  gap_timer #(.W(CNT_W), .NSRC(3)) u_pre_gap (
    .clk  (clk),
    .rst  (rst),
    .load ({act_me, rd_me, wr_me}),
    .span ({t_act_pre, t_rd_pre, t_wr_pre}),
    .idle (pre_ok)
  );

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
    act_me |=> (open_o && row_o == $past(fire_row)));

  assert_pre_closes_R4: assert property (@(posedge clk) disable iff (rst)
    (pre_me || prea_all) |=> !open_o);

  assert_ras_blocks_pre_R4: assert property (@(posedge clk) disable iff (rst)
    (act_me && t_act_pre > 8'd1) |=> !pre_ok);

  assert_hold_when_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(open_o) && $stable(row_o)));
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
  import bank_trk_pkg::*;
#(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned ROW_W  = 14,
  localparam int unsigned BANK_W = $clog2(NBANK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cfg_act_pre,
  input  logic [CNT_W-1:0]    cfg_act_rw,
  input  logic [CNT_W-1:0]    cfg_pre_act,
  input  logic [CNT_W-1:0]    cfg_wr_pre,
  input  logic [CNT_W-1:0]    cfg_rd_pre,
  input  logic [CNT_W-1:0]    cfg_wr_rd,
  input  logic [CNT_W-1:0]    cfg_act_xb,
  input  logic [CNT_W-1:0]    cfg_act_sb,
  input  logic [CNT_W-1:0]    cfg_ref_act,
  input  logic [CNT_W-1:0]    cfg_mrs_cmd,
  input  logic [CNT_W-1:0]    cfg_srx_cmd,
  input  logic [CNT_W-1:0]    cfg_srx_rd,
  input  logic [CNT_W-1:0]    cfg_pdx_cmd,
  input  logic                cmd_valid,
  input  logic [OP_W-1:0]     cmd_op,
  input  logic [BANK_W-1:0]   cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  output logic [1:0]          q_status,
  output logic [NUM_OPS-1:0]  allow,
  output logic                cmd_accept,
  output logic [NBANK-1:0]    open_mask
);
  localparam int unsigned OP_SPACE = 2 ** OP_W;

  timing_t tcfg_q;

  // Spacing set is loaded while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      tcfg_q <= '{act_pre: cfg_act_pre, act_rw: cfg_act_rw, pre_act: cfg_pre_act,
                  wr_pre: cfg_wr_pre, rd_pre: cfg_rd_pre, wr_rd: cfg_wr_rd,
                  act_xb: cfg_act_xb, act_sb: cfg_act_sb, ref_act: cfg_ref_act,
                  mrs_cmd: cfg_mrs_cmd, srx_cmd: cfg_srx_cmd, srx_rd: cfg_srx_rd,
                  pdx_cmd: cfg_pdx_cmd};
    end
  end

  logic [NBANK-1:0]  open_v, act_ok_v, rw_ok_v, pre_ok_v;
  logic [ROW_W-1:0]  row_v [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .fire      (cmd_accept),
      .fire_op   (cmd_op),
      .fire_here (cmd_bank == BANK_W'(b)),
      .fire_row  (cmd_row),
      .t_act_sb  (tcfg_q.act_sb),
      .t_act_xb  (tcfg_q.act_xb),
      .t_pre_act (tcfg_q.pre_act),
      .t_ref_act (tcfg_q.ref_act),
      .t_mrs_cmd (tcfg_q.mrs_cmd),
      .t_act_rw  (tcfg_q.act_rw),
      .t_act_pre (tcfg_q.act_pre),
      .t_rd_pre  (tcfg_q.rd_pre),
      .t_wr_pre  (tcfg_q.wr_pre),
      .open_o    (open_v[b]),
      .row_o     (row_v[b]),
      .act_ok    (act_ok_v[b]),
      .rw_ok     (rw_ok_v[b]),
      .pre_ok    (pre_ok_v[b])
    );
  end

  // Device-wide gates: exit spacings for everything, and the read-only gate.
  logic fire_wr, fire_srx, fire_pdx, any_ok, rd_ok;
  assign fire_wr  = cmd_accept && (cmd_op == OP_WR);
  assign fire_srx = cmd_accept && (cmd_op == OP_SRX);
  assign fire_pdx = cmd_accept && (cmd_op == OP_PDX);

  gap_timer #(.W(CNT_W), .NSRC(2)) u_any_gap (
    .clk  (clk),
    .rst  (rst),
    .load ({fire_srx, fire_pdx}),
    .span ({tcfg_q.srx_cmd, tcfg_q.pdx_cmd}),
    .idle (any_ok)
  );

  gap_timer #(.W(CNT_W), .NSRC(3)) u_rd_gap (
    .clk  (clk),
    .rst  (rst),
    .load ({fire_wr, fire_srx, fire_pdx}),
    .span ({tcfg_q.wr_rd, tcfg_q.srx_rd, tcfg_q.pdx_cmd}),
    .idle (rd_ok)
  );

  logic sel_open, sel_hit, all_idle, all_act, prea_ok;
  assign sel_open = open_v[cmd_bank];
  assign sel_hit  = sel_open && (row_v[cmd_bank] == cmd_row);
  assign all_idle = ~|open_v;
  assign all_act  = &act_ok_v;
  assign prea_ok  = &(pre_ok_v | ~open_v);

  always_comb begin
    if (!sel_open)    q_status = ST_IDLE;
    else if (sel_hit) q_status = ST_HIT;
    else              q_status = ST_MISS;
  end

  always_comb begin
    allow          = '0;
    allow[OP_NOP]  = 1'b1;
    allow[OP_ACT]  = !sel_open && act_ok_v[cmd_bank] && any_ok;
    allow[OP_RD]   = sel_hit && rw_ok_v[cmd_bank] && any_ok && rd_ok;
    allow[OP_WR]   = sel_hit && rw_ok_v[cmd_bank] && any_ok;
    allow[OP_PRE]  = sel_open && pre_ok_v[cmd_bank] && any_ok;
    allow[OP_PREA] = prea_ok && any_ok;
    allow[OP_REF]  = all_idle && all_act && any_ok;
    allow[OP_MRS]  = all_idle && all_act && any_ok;
    allow[OP_SRX]  = 1'b1;
    allow[OP_PDX]  = 1'b1;
  end

  logic [OP_SPACE-1:0] allow_ext;
  assign allow_ext  = {{(OP_SPACE-NUM_OPS){1'b0}}, allow};
  assign cmd_accept = cmd_valid && allow_ext[cmd_op];
  assign open_mask  = open_v;

  assert_act_on_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_op == OP_ACT) |-> (q_status == ST_IDLE));

  assert_access_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> (q_status == ST_HIT));

  assert_wtr_blocks_read_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_op == OP_WR && tcfg_q.wr_rd > 8'd1) |=> !allow[OP_RD]);

  assert_prea_closes_all_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_op == OP_PREA) |=> (open_mask == '0));

  assert_ref_needs_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && (cmd_op == OP_REF || cmd_op == OP_MRS)) |-> (open_mask == '0));

  assert_srx_blocks_act_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_op == OP_SRX && tcfg_q.srx_cmd > 8'd1) |=> !allow[OP_ACT]);

  assert_bad_code_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op > 4'd9) |-> !cmd_accept);
endmodule

// File: tb/bank_timing_tracker_bench.sv
module bank_timing_tracker_bench;
  localparam int ROW_W = 14;

  // Spacing index order inside each configuration row.
  localparam int I_RAS = 0, I_RCD = 1, I_RP = 2, I_WR = 3, I_RTP = 4, I_WTR = 5, I_RRD = 6,
                 I_RC = 7, I_RFC = 8, I_MRD = 9, I_XSNR = 10, I_XSRD = 11, I_XP = 12;
  localparam int NCFG = 3;

  int cfgv [NCFG][13] = '{
    '{6, 2, 2, 2, 1, 1, 1, 8, 14, 2, 16, 200, 2},
    '{3, 1, 4, 5, 3, 3, 2, 9, 5, 3, 4, 7, 3},
    '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg [13];
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic [ROW_W-1:0] cmd_row = '0;
  logic [1:0] q_status;
  logic [9:0] allow;
  logic cmd_accept;
  logic [3:0] open_mask;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int kc = 0;

  always #4 clk = ~clk;

  bank_timing_tracker u_bank_timing_tracker (
    .clk(clk), .rst(rst),
    .cfg_act_pre(cfg[I_RAS]), .cfg_act_rw(cfg[I_RCD]), .cfg_pre_act(cfg[I_RP]),
    .cfg_wr_pre(cfg[I_WR]), .cfg_rd_pre(cfg[I_RTP]), .cfg_wr_rd(cfg[I_WTR]),
    .cfg_act_xb(cfg[I_RRD]), .cfg_act_sb(cfg[I_RC]), .cfg_ref_act(cfg[I_RFC]),
    .cfg_mrs_cmd(cfg[I_MRD]), .cfg_srx_cmd(cfg[I_XSNR]), .cfg_srx_rd(cfg[I_XSRD]),
    .cfg_pdx_cmd(cfg[I_XP]),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .q_status(q_status), .allow(allow), .cmd_accept(cmd_accept), .open_mask(open_mask)
  );

  function automatic int g(int idx);
    return (cfgv[kc][idx] < 1) ? 1 : cfgv[kc][idx];
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s cfg%0d actual=%0d expected=%0d", tag, kc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic drive(input bit v, input int op, input int b, input int r);
    cmd_valid = v;
    cmd_op    = 4'(op);
    cmd_bank  = 2'(b);
    cmd_row   = ROW_W'(r);
    #1;
  endtask

  task automatic issue(input int op, input int b, input int r, output bit acc);
    drive(1'b1, op, b, r);
    acc = cmd_accept;
    tick();
    cmd_valid = 1'b0;
  endtask

  // Cycles from the last issue until the allow bit of op first rises.
  task automatic gap(input int op, input int b, input int r, input int exp, input string tag);
    int n;
    drive(1'b0, op, b, r);
    n = 1;
    while (!allow[op] && n < 400) begin
      tick();
      n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic do_reset();
    for (int i = 0; i < 13; i++) cfg[i] = 8'(cfgv[kc][i]);
    cmd_valid = 1'b0;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit acc;
    for (int k = 0; k < NCFG; k++) begin
      kc = k;
      // R1: reset state
      do_reset();
      drive(1'b0, 1, 0, 0);
      check(open_mask == 4'd0, "R1 open_mask after reset", open_mask, 0);
      check(q_status == 2'd0, "R1 status idle", q_status, 0);
      check(allow[1] == 1'b1, "R1 ACT allowed at once", allow[1], 1);
      check(allow[2] == 1'b0, "R1 RD blocked on idle bank", allow[2], 0);
      check(allow[4] == 1'b0, "R4 PRE blocked on idle bank", allow[4], 0);

      // R3 / R2: activate to access, hit and miss
      do_reset();
      issue(1, 0, 5, acc);
      check(acc, "R2 ACT accepted", acc, 1);
      gap(2, 0, 5, g(I_RCD), "R3 ACT->RD gap");
      check(q_status == 2'd1, "R2 status hit", q_status, 1);
      drive(1'b0, 2, 0, 6);
      check(q_status == 2'd2, "R2 status miss", q_status, 2);
      check(allow[2] == 1'b0, "R3 RD on miss blocked", allow[2], 0);
      check(allow[3] == 1'b0, "R3 WR on miss blocked", allow[3], 0);

      // R4 / R5: activate to precharge, then row cycle versus precharge gap
      do_reset();
      issue(1, 0, 2, acc);
      gap(4, 0, 2, g(I_RAS), "R4 ACT->PRE gap");
      issue(4, 0, 2, acc);
      check(open_mask == 4'd0, "R4 PRE closes bank", open_mask, 0);
      gap(1, 0, 2, max2(g(I_RP), g(I_RC) - g(I_RAS)), "R5 R12 ACT after PRE");

      // R5: bank-to-bank activate
      do_reset();
      issue(1, 0, 1, acc);
      gap(1, 1, 1, g(I_RRD), "R5 ACT->ACT other bank");

      // R4: read to precharge
      do_reset();
      issue(1, 0, 3, acc);
      gap(2, 0, 3, g(I_RCD), "R3 ACT->RD gap");
      issue(2, 0, 3, acc);
      gap(4, 0, 3, max2(g(I_RTP), g(I_RAS) - g(I_RCD)), "R4 RD->PRE gap");

      // R4: write to precharge
      do_reset();
      issue(1, 0, 3, acc);
      gap(3, 0, 3, g(I_RCD), "R3 ACT->WR gap");
      issue(3, 0, 3, acc);
      gap(4, 0, 3, max2(g(I_WR), g(I_RAS) - g(I_RCD)), "R4 WR->PRE gap");

      // R6: write on one bank holds reads on another
      do_reset();
      issue(1, 0, 1, acc);
      gap(1, 1, 2, g(I_RRD), "R5 ACT->ACT other bank");
      issue(1, 1, 2, acc);
      gap(3, 1, 2, g(I_RCD), "R3 ACT->WR gap");
      issue(3, 1, 2, acc);
      gap(2, 0, 1, g(I_WTR), "R6 WR->RD cross bank");

      // R7: precharge-all
      do_reset();
      issue(1, 0, 1, acc);
      gap(1, 1, 2, g(I_RRD), "R5 ACT->ACT other bank");
      issue(1, 1, 2, acc);
      gap(5, 0, 0, g(I_RAS), "R7 PREA waits last ACT");
      issue(5, 0, 0, acc);
      check(open_mask == 4'd0, "R7 PREA closes all", open_mask, 0);
      gap(1, 2, 0, g(I_RP), "R7 ACT after PREA");

      // R8 / R9: refresh and mode load need idle banks
      do_reset();
      issue(1, 0, 1, acc);
      drive(1'b0, 6, 0, 0);
      check(allow[6] == 1'b0, "R8 REF blocked with open bank", allow[6], 0);
      check(allow[7] == 1'b0, "R9 MRS blocked with open bank", allow[7], 0);
      gap(4, 0, 1, g(I_RAS), "R4 ACT->PRE gap");
      issue(4, 0, 1, acc);
      gap(6, 0, 0, max2(g(I_RP), max2(g(I_RC) - g(I_RAS), g(I_RRD) - g(I_RAS))),
          "R8 REF after PRE");
      issue(6, 0, 0, acc);
      check(acc, "R8 REF accepted", acc, 1);
      gap(1, 1, 0, g(I_RFC), "R8 REF->ACT gap");

      // R9: mode load
      do_reset();
      issue(7, 0, 0, acc);
      check(acc, "R9 MRS accepted", acc, 1);
      gap(6, 0, 0, g(I_MRD), "R9 MRS->REF gap");

      // R10: self-refresh exit
      do_reset();
      issue(8, 0, 0, acc);
      gap(1, 0, 4, g(I_XSNR), "R10 SRX->ACT gap");
      issue(1, 0, 4, acc);
      gap(2, 0, 4, max2(g(I_RCD), g(I_XSRD) - g(I_XSNR)), "R10 SRX->RD gap");

      // R10: power-down exit
      do_reset();
      issue(9, 0, 0, acc);
      gap(1, 3, 0, g(I_XP), "R10 PDX->ACT gap");

      // R11: rejected commands leave state alone
      do_reset();
      issue(2, 0, 1, acc);
      check(!acc, "R11 RD on idle rejected", acc, 0);
      issue(12, 0, 1, acc);
      check(!acc, "R11 undefined code rejected", acc, 0);
      check(open_mask == 4'd0, "R11 no bank opened", open_mask, 0);
      issue(1, 0, 7, acc);
      issue(1, 0, 9, acc);
      check(!acc, "R11 ACT on open bank rejected", acc, 0);
      drive(1'b0, 0, 0, 7);
      check(q_status == 2'd1, "R11 row kept", q_status, 1);
      if (g(I_RAS) > 2) begin
        issue(4, 0, 7, acc);
        check(!acc, "R11 early PRE rejected", acc, 0);
        check(open_mask == 4'd1, "R11 bank still open", open_mask, 1);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule